// File: doc/BRIEF.md
# Port-Selected Duplicated Register File

This block is the control register store of a receiver with two link ports. A host reaches it over a plain synchronous register bus: address, write data, a write strobe, a read strobe and registered read data. Some registers exist once and are shared by both ports. Others are duplicated, with one copy for port 0 and one for port 1. A parameter table lists every mapped address and marks it as shared or duplicated.

A two-bit port-select register at address 0x34 decides which copy of a duplicated register the host reaches. A write goes to every selected port in the same cycle, so one write can set up both ports. A read returns a single copy chosen by a fixed priority that favours port 1. Shared registers ignore the select bits. The contents of every register are brought out as two flat vectors, one for each port, so the link logic of each port sees its own view.

Top module: `regsel_regfile`

## Requirements
- R1: The port-select register is at address 0x34. Bit 0 selects port 0 and bit 1 selects port 1. It resets to 2'b01. Bits 7..2 read as zero and are not stored.
- R2: A shared register is written and read the same way whatever the select bits hold, and its value appears in its slot of both port output vectors.
- R3: A write to a duplicated register with exactly one select bit set updates only that port's copy.
- R4: A write to a duplicated register with both select bits set updates both copies in the same clock cycle.
- R5: A write to a duplicated register with select 2'b00 changes neither copy.
- R6: A read of a duplicated register returns the copy of the selected port. With both bits set it returns the port 1 copy.
- R7: A read of a duplicated register with select 2'b00 returns zero.
- R8: An address that is neither mapped nor 0x34 reads as zero, and writes to it change no register.
- R9: Read data is registered. It shows the value one clock after the read strobe and holds while the strobe is low. A read and a write to the same address in the same cycle return the value from before the write.
- R10: Reset clears every stored register and the read data to zero, and sets the select to 2'b01.
- R11: Entry i of the map occupies bits [8i+7:8i] of each port output vector. The default map is: entry 0 at 0x00 shared, entry 1 at 0x02 duplicated, entry 2 at 0x03 duplicated, entry 3 at 0x10 shared, entry 4 at 0x21 duplicated, entry 5 at 0x40 shared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | AW (8) | Register address |
| bus_wdata | input | DW (8) | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DW (8) | Registered read data |
| p0_regs | output | N*DW (48) | Port 0 view of all map entries |
| p1_regs | output | N*DW (48) | Port 1 view of all map entries |

## Verification
A wrong select value can stay hidden until the next access to a duplicated register. The first read after it shows the wrong copy one clock after the strobe. A write with a wrong select shows up on the port vectors on the next clock, as the wrong slot changing or the right slot standing still. A decode fault that merges a shared and a duplicated entry shows up on the next write, as the two port views of a shared slot drifting apart. A fault in the held read data shows up on the idle cycles after a read.

// File: rtl/regsel_pkg.sv
package regsel_pkg;

  typedef enum logic [1:0] {
    ACC_NONE   = 2'd0,
    ACC_PSEL   = 2'd1,
    ACC_SHARED = 2'd2,
    ACC_DUP    = 2'd3
  } acc_kind_t;

  // One-hot choice of which copy a read returns: port 1 wins when both are set.
  function automatic logic [1:0] rd_pick(input logic [1:0] sel);
    logic [1:0] pick;
    if (sel[1])      pick = 2'b10;
    else if (sel[0]) pick = 2'b01;
    else             pick = 2'b00;
    return pick;
  endfunction

  // Ports a write reaches: every selected port for a duplicated entry, both
  // storage slots for a shared entry.
  function automatic logic [1:0] wr_mask(input logic [1:0] sel, input logic is_dup);
    return is_dup ? sel : 2'b11;
  endfunction

endpackage

// File: rtl/regsel_decode.sv
module regsel_decode
  import regsel_pkg::*;
#(
  parameter int N = 6,
  parameter int AW = 8,
  parameter logic [N*AW-1:0] MAP_ADDR = '0,
  parameter logic [N-1:0] MAP_DUP = '0,
  parameter logic [AW-1:0] PSEL_ADDR = 8'h34,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [AW-1:0] addr,
  output logic [N-1:0]  hit_vec,
  output logic [IW-1:0] hit_idx,
  output acc_kind_t     kind
);

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hit_vec[i] = (addr == MAP_ADDR[i*AW +: AW]);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (hit_vec[i]) hit_idx = IW'(i);
    end
  end

  always_comb begin
    if (addr == PSEL_ADDR)        kind = ACC_PSEL;
    else if (|(hit_vec & MAP_DUP)) kind = ACC_DUP;
    else if (|hit_vec)             kind = ACC_SHARED;
    else                           kind = ACC_NONE;
  end

endmodule

// File: rtl/regsel_psel.sv
module regsel_psel #(
  parameter logic [1:0] RESET_SEL = 2'b01
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [1:0] wsel,
  output logic [1:0] sel
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  sel <= RESET_SEL;
    else if (wr) sel <= wsel;
  end

endmodule

// File: rtl/regsel_bank.sv
module regsel_bank #(
  parameter int N = 6,
  parameter int DW = 8,
  parameter logic [N-1:0] MAP_DUP = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  wr_hit,
  input  logic [1:0]    port_mask,
  input  logic [DW-1:0] wdata,
  output logic [N*DW-1:0] p0_flat,
  output logic [N*DW-1:0] p1_flat
);

  for (genvar i = 0; i < N; i++) begin : g_ent
    if (MAP_DUP[i]) begin : g_dup
      logic [DW-1:0] copy0, copy1;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          copy0 <= '0;
          copy1 <= '0;
        end else begin
          if (wr_hit[i] && port_mask[0]) copy0 <= wdata;
          if (wr_hit[i] && port_mask[1]) copy1 <= wdata;
        end
      end
      assign p0_flat[i*DW +: DW] = copy0;
      assign p1_flat[i*DW +: DW] = copy1;
    end else begin : g_shr
      logic [DW-1:0] val;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         val <= '0;
        else if (wr_hit[i]) val <= wdata;
      end
      assign p0_flat[i*DW +: DW] = val;
      assign p1_flat[i*DW +: DW] = val;
    end
  end

endmodule

// File: rtl/regsel_rdmux.sv
module regsel_rdmux
  import regsel_pkg::*;
#(
  parameter int N = 6,
  parameter int DW = 8
) (
  input  acc_kind_t       kind,
  input  logic [N-1:0]    hit_vec,
  input  logic [1:0]      sel,
  input  logic [N*DW-1:0] p0_flat,
  input  logic [N*DW-1:0] p1_flat,
  output logic [DW-1:0]   rd_value
);

  logic [1:0] pick;
  assign pick = rd_pick(sel);

  always_comb begin
    rd_value = '0;
    unique case (kind)
      ACC_PSEL: rd_value = {{(DW-2){1'b0}}, sel};
      ACC_SHARED: begin
        for (int i = 0; i < N; i++)
          if (hit_vec[i]) rd_value = rd_value | p0_flat[i*DW +: DW];
      end
      ACC_DUP: begin
        for (int i = 0; i < N; i++) begin
          if (hit_vec[i] && pick[1]) rd_value = rd_value | p1_flat[i*DW +: DW];
          if (hit_vec[i] && pick[0]) rd_value = rd_value | p0_flat[i*DW +: DW];
        end
      end
      default: rd_value = '0;
    endcase
  end

endmodule

// File: rtl/regsel_regfile.sv
module regsel_regfile
  import regsel_pkg::*;
#(
  parameter int N = 6,
  parameter int AW = 8,
  parameter int DW = 8,
  parameter logic [N*AW-1:0] MAP_ADDR = {8'h40, 8'h21, 8'h10, 8'h03, 8'h02, 8'h00},
  parameter logic [N-1:0] MAP_DUP = 6'b010110,
  parameter logic [AW-1:0] PSEL_ADDR = 8'h34,
  parameter logic [1:0] PSEL_RESET = 2'b01,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  input  logic            bus_wr,
  input  logic            bus_rd,
  output logic [DW-1:0]   bus_rdata,
  output logic [N*DW-1:0] p0_regs,
  output logic [N*DW-1:0] p1_regs
);

  acc_kind_t     acc_kind;
  logic [N-1:0]  hit_vec;
  logic [IW-1:0] hit_idx;
  logic [1:0]    port_sel;
  logic [1:0]    port_mask;
  logic [N-1:0]  wr_hit;
  logic [DW-1:0] rd_value;

  // named events for the checker
  logic wr_psel_evt, wr_shared_evt, wr_dup_evt;
  assign wr_psel_evt   = bus_wr && (acc_kind == ACC_PSEL);
  assign wr_shared_evt = bus_wr && (acc_kind == ACC_SHARED);
  assign wr_dup_evt    = bus_wr && (acc_kind == ACC_DUP);

  regsel_decode #(
    .N(N), .AW(AW), .MAP_ADDR(MAP_ADDR), .MAP_DUP(MAP_DUP), .PSEL_ADDR(PSEL_ADDR)
  ) u_dec (
    .addr(bus_addr), .hit_vec(hit_vec), .hit_idx(hit_idx), .kind(acc_kind)
  );

  regsel_psel #(.RESET_SEL(PSEL_RESET)) u_psel (
    .clk(clk), .rst_n(rst_n), .wr(wr_psel_evt), .wsel(bus_wdata[1:0]), .sel(port_sel)
  );

  assign port_mask = wr_mask(port_sel, wr_dup_evt);
  assign wr_hit    = (wr_shared_evt || wr_dup_evt) ? hit_vec : '0;

  regsel_bank #(.N(N), .DW(DW), .MAP_DUP(MAP_DUP)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .port_mask(port_mask),
    .wdata(bus_wdata), .p0_flat(p0_regs), .p1_flat(p1_regs)
  );

  regsel_rdmux #(.N(N), .DW(DW)) u_rd (
    .kind(acc_kind), .hit_vec(hit_vec), .sel(port_sel),
    .p0_flat(p0_regs), .p1_flat(p1_regs), .rd_value(rd_value)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_value;
  end

endmodule

// File: rtl/regsel_checker.sv
module regsel_checker
  import regsel_pkg::*;
#(
  parameter int N = 6,
  parameter int DW = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_rd,
  input logic [DW-1:0]   bus_wdata,
  input logic [DW-1:0]   bus_rdata,
  input logic [N*DW-1:0] p0_regs,
  input logic [N*DW-1:0] p1_regs,
  input logic [1:0]      port_sel,
  input acc_kind_t       acc_kind,
  input logic [IW-1:0]   hit_idx,
  input logic            wr_shared_evt,
  input logic            wr_dup_evt
);

  logic [IW-1:0] last_idx;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_idx <= '0;
    else        last_idx <= hit_idx;
  end

  logic [DW-1:0] p0_last, p1_last;
  assign p0_last = p0_regs[last_idx*DW +: DW];
  assign p1_last = p1_regs[last_idx*DW +: DW];

  AST_PSEL_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && acc_kind == ACC_PSEL) |=> (bus_rdata[DW-1:2] == '0)); // R1

  AST_SHARED_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    wr_shared_evt |=> (p0_last == $past(bus_wdata) && p1_last == $past(bus_wdata))); // R2

  AST_DUP_ONLY_P0: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dup_evt && port_sel == 2'b01) |=> (p0_last == $past(bus_wdata) && $stable(p1_regs))); // R3

  AST_DUP_ONLY_P1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dup_evt && port_sel == 2'b10) |=> (p1_last == $past(bus_wdata) && $stable(p0_regs))); // R3

  AST_DUP_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dup_evt && port_sel == 2'b11) |=> (p0_last == $past(bus_wdata) && p1_last == $past(bus_wdata))); // R4

  AST_DUP_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dup_evt && port_sel == 2'b00) |=> ($stable(p0_regs) && $stable(p1_regs))); // R5

  AST_DUP_RD_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && acc_kind == ACC_DUP && port_sel == 2'b00) |=> (bus_rdata == '0)); // R7

  AST_UNMAPPED_RD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && acc_kind == ACC_NONE) |=> (bus_rdata == '0)); // R8

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata)); // R9

endmodule

bind regsel_regfile regsel_checker #(.N(N), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .p0_regs(p0_regs), .p1_regs(p1_regs),
  .port_sel(port_sel), .acc_kind(acc_kind), .hit_idx(hit_idx),
  .wr_shared_evt(wr_shared_evt), .wr_dup_evt(wr_dup_evt)
);

// File: tb/sim_regsel_regfile.sv
module sim_regsel_regfile;

  localparam int N = 6;
  localparam int DW = 8;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic bus_wr = 1'b0;
  logic bus_rd = 1'b0;
  logic [DW-1:0] bus_rdata;
  logic [N*DW-1:0] p0_regs, p1_regs;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  regsel_regfile u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .p0_regs(p0_regs), .p1_regs(p1_regs)
  );

  // vector: {is_read, addr, wdata, expected, requirement}
  localparam int NV = 32;
  localparam logic [28:0] VEC [NV] = '{
    {1'b1, 8'h34, 8'h00, 8'h01, 4'd1},  // R1 reset select
    {1'b0, 8'h02, 8'hA1, 8'h00, 4'd0},
    {1'b1, 8'h02, 8'h00, 8'hA1, 4'd3},  // R3 port 0 copy
    {1'b0, 8'h34, 8'h02, 8'h00, 4'd0},
    {1'b1, 8'h02, 8'h00, 8'h00, 4'd3},  // R3 port 1 untouched
    {1'b0, 8'h02, 8'hB2, 8'h00, 4'd0},
    {1'b1, 8'h02, 8'h00, 8'hB2, 4'd6},  // R6
    {1'b0, 8'h34, 8'h01, 8'h00, 4'd0},
    {1'b1, 8'h02, 8'h00, 8'hA1, 4'd6},
    {1'b0, 8'h34, 8'h03, 8'h00, 4'd0},
    {1'b1, 8'h02, 8'h00, 8'hB2, 4'd6},  // R6 both set -> port 1
    {1'b0, 8'h03, 8'hC3, 8'h00, 4'd0},
    {1'b0, 8'h34, 8'h01, 8'h00, 4'd0},
    {1'b1, 8'h03, 8'h00, 8'hC3, 4'd4},  // R4
    {1'b0, 8'h34, 8'h02, 8'h00, 4'd0},
    {1'b1, 8'h03, 8'h00, 8'hC3, 4'd4},
    {1'b0, 8'h34, 8'h00, 8'h00, 4'd0},
    {1'b0, 8'h02, 8'hFF, 8'h00, 4'd0},
    {1'b1, 8'h02, 8'h00, 8'h00, 4'd7},  // R7
    {1'b1, 8'h34, 8'h00, 8'h00, 4'd1},
    {1'b0, 8'h00, 8'h5A, 8'h00, 4'd0},
    {1'b1, 8'h00, 8'h00, 8'h5A, 4'd2},  // R2 with no select
    {1'b0, 8'h34, 8'hFE, 8'h00, 4'd0},
    {1'b1, 8'h34, 8'h00, 8'h02, 4'd1},  // R1 upper bits dropped
    {1'b1, 8'h00, 8'h00, 8'h5A, 4'd2},
    {1'b1, 8'h02, 8'h00, 8'hB2, 4'd5},  // R5 port 1 kept
    {1'b0, 8'h34, 8'h01, 8'h00, 4'd0},
    {1'b1, 8'h02, 8'h00, 8'hA1, 4'd5},  // R5 port 0 kept
    {1'b0, 8'h07, 8'h77, 8'h00, 4'd0},
    {1'b1, 8'h07, 8'h00, 8'h00, 4'd8},  // R8
    {1'b0, 8'h35, 8'h88, 8'h00, 4'd0},
    {1'b1, 8'h35, 8'h00, 8'h00, 4'd8}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [DW-1:0] slot(input logic [N*DW-1:0] v, input int i);
    return v[i*DW +: DW];
  endfunction

  initial begin
    logic [DW-1:0] rv;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 rdata", 64'(bus_rdata), 64'h0);
    check("R10 p0", 64'(p0_regs), 64'h0);
    check("R10 p1", 64'(p1_regs), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      if (VEC[k][28]) begin
        do_read(VEC[k][27:20], rv);
        check($sformatf("R%0d vec %0d", VEC[k][3:0], k), 64'(rv), 64'(VEC[k][11:4]));
      end else begin
        do_write(VEC[k][27:20], VEC[k][19:12]);
      end
    end

    // R11 slot layout and per-port views
    check("R11 p0 slot1", 64'(slot(p0_regs, 1)), 64'hA1);
    check("R11 p1 slot1", 64'(slot(p1_regs, 1)), 64'hB2);
    check("R4 p0 slot2", 64'(slot(p0_regs, 2)), 64'hC3);
    check("R4 p1 slot2", 64'(slot(p1_regs, 2)), 64'hC3);
    check("R2 p0 slot0", 64'(slot(p0_regs, 0)), 64'h5A);
    check("R2 p1 slot0", 64'(slot(p1_regs, 0)), 64'h5A);
    check("R8 other slots", 64'({slot(p0_regs, 3), slot(p0_regs, 4), slot(p0_regs, 5),
                                 slot(p1_regs, 3), slot(p1_regs, 4), slot(p1_regs, 5)}), 64'h0);

    // R9 hold while strobe low
    do_read(8'h02, rv);
    bus_addr = 8'h03;
    repeat (2) @(negedge clk);
    check("R9 hold", 64'(bus_rdata), 64'hA1);

    // R9 read and write to the same address in one cycle
    @(negedge clk);
    bus_addr = 8'h00; bus_wdata = 8'h66; bus_wr = 1'b1; bus_rd = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    check("R9 old value", 64'(bus_rdata), 64'h5A);
    check("R2 new shared", 64'(slot(p1_regs, 0)), 64'h66);
    do_read(8'h00, rv);
    check("R9 new value", 64'(rv), 64'h66);

    // R3 port 1 only write through the outputs
    do_write(8'h34, 8'h02);
    do_write(8'h21, 8'h3C);
    check("R3 p1 slot4", 64'(slot(p1_regs, 4)), 64'h3C);
    check("R3 p0 slot4", 64'(slot(p0_regs, 4)), 64'h00);

    // R10 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R10 rdata again", 64'(bus_rdata), 64'h0);
    check("R10 p0 again", 64'(p0_regs), 64'h0);
    check("R10 p1 again", 64'(p1_regs), 64'h0);
    rst_n = 1'b1;
    do_read(8'h34, rv);
    check("R10 select", 64'(rv), 64'h01);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule